// File: doc/BRIEF.md
# Logarithmic-depth prefix-tree binary adder

This block adds two unsigned N-bit operands and a carry input. The result is an N-bit sum and a carry output, and it is fully combinational. Each bit position first classifies itself: it either generates a carry (both operand bits set) or propagates one (operand bits differ). Those per-bit pairs are merged by an associative merge cell. The merge cells form two binary trees. The first tree sweeps upward and builds prefix pairs that cover spans of 2, 4, 8 and so on, up to the whole word. The second tree sweeps downward and completes every prefix that the first tree left partial.

The carry input is treated as a generating position just below bit 0. The carry into bit i+1 is therefore the prefix generate of bits i..0, OR-ed with the prefix propagate ANDed with the carry input. Each sum bit is then a single XOR of the bit's propagate with its incoming carry. The carry path is about 2·log2(N)−1 merge levels deep, and the sum adds one fixed level on top of it.

Top module: `bk_prefix_adder`

## Requirements
- R1: For any inputs, {carry_out, sum_out} equals opnd_a + opnd_b + carry_in as an (N+1)-bit unsigned value.
- R2: A bit position where both operand bits are 1 makes the carry into the next position 1, whatever the lower bits and carry_in are.
- R3: A bit position where both operand bits are 0 makes the carry into the next position 0, whatever the lower bits and carry_in are.
- R4: A bit position where exactly one operand bit is 1 passes its incoming carry unchanged. With opnd_b = ~opnd_a, carry_out equals carry_in, and sum_out is all ones when carry_in is 0 and all zeros when carry_in is 1.
- R5: carry_in enters the addition at weight 1: with both operands zero, sum_out equals carry_in and carry_out is 0.
- R6: The width N is a parameter that must be a power of two and at least 4; any other value stops elaboration. At N=8 and at N=16 the block satisfies R1.
- R7: The outputs follow the inputs with no clock and hold no state; all-zero inputs give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | First operand |
| opnd_b | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | N | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds two copies of the adder, one with N=16 and one with N=8. The 8-bit copy is driven with every operand pair under both carry-in values. This exhaustive sweep covers every generate, kill and propagate pattern that a three-level up-sweep and two-level down-sweep can see. The 16-bit copy is driven with a vector table, full-length propagate chains, and random operands with a forced generate or kill at each position. These reach the deeper trees, where the down-sweep fills interior prefixes such as bits 11..0 from two partial spans.

// File: rtl/bkpa_pkg.sv
package bkpa_pkg;

  // Generate / propagate pair describing one bit or one span of bits.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Merge a more significant span (hi) with the adjacent lower span (lo).
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Classify one bit position from its two operand bits.
  function automatic gp_t gp_leaf(input logic a, input logic b);
    gp_t r;
    r.g = a & b;
    r.p = a ^ b;
    return r;
  endfunction

endpackage

// File: rtl/bk_bitcell.sv
module bk_bitcell
  import bkpa_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]  a,
  input  logic [N-1:0]  b,
  output gp_t  [N-1:0]  leaf
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign leaf[i] = gp_leaf(a[i], b[i]);
  end

endmodule

// File: rtl/bk_gp_cell.sv
module bk_gp_cell
  import bkpa_pkg::*;
(
  input  gp_t hi,
  input  gp_t lo,
  output gp_t y
);

  assign y = gp_merge(hi, lo);

endmodule

// File: rtl/bk_prefix_tree.sv
module bk_prefix_tree
  import bkpa_pkg::*;
#(
  parameter int N = 16
) (
  input  gp_t [N-1:0] leaf,
  output gp_t [N-1:0] pre
);

  localparam int LG   = $clog2(N);
  localparam int NSTG = 2 * LG - 1;

  // Stage 0 holds the leaves; stage NSTG holds full prefixes (i..0).
  gp_t [NSTG:0][N-1:0] stg;

  assign stg[0] = leaf;

  // Up-sweep: stride D doubles each stage, merges at the top of each 2D block.
  for (genvar l = 0; l < LG; l++) begin : g_up
    localparam int D = 1 << l;
    for (genvar i = 0; i < N; i++) begin : g_col
      if (((i + 1) % (2 * D)) == 0) begin : g_mrg
        bk_gp_cell u_cell (
          .hi (stg[l][i]),
          .lo (stg[l][i-D]),
          .y  (stg[l+1][i])
        );
      end else begin : g_pass
        assign stg[l+1][i] = stg[l][i];
      end
    end
  end

  // Down-sweep: stride halves from N/4 to 1, completing interior prefixes.
  for (genvar k = 0; k < LG - 1; k++) begin : g_dn
    localparam int D  = 1 << (LG - 2 - k);
    localparam int SI = LG + k;
    for (genvar i = 0; i < N; i++) begin : g_col
      if ((((i + 1) % (2 * D)) == D) && ((i + 1) > 2 * D)) begin : g_mrg
        bk_gp_cell u_cell (
          .hi (stg[SI][i]),
          .lo (stg[SI][i-D]),
          .y  (stg[SI+1][i])
        );
      end else begin : g_pass
        assign stg[SI+1][i] = stg[SI][i];
      end
    end
  end

  assign pre = stg[NSTG];

endmodule

// File: rtl/bk_sum_stage.sv
module bk_sum_stage
  import bkpa_pkg::*;
#(
  parameter int N = 16
) (
  input  gp_t [N-1:0] leaf,
  input  gp_t [N-1:0] pre,
  input  logic        cin,
  output logic [N-1:0] s,
  output logic        cout
);

  // carry[i] is the carry into bit i; carry[0] is the external carry.
  logic [N:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign carry[i+1] = pre[i].g | (pre[i].p & cin);
    assign s[i]       = leaf[i].p ^ carry[i];

    // Local carry rules, checking tree carries against the bit cells.
    always_comb begin
      if (!$isunknown({leaf[i], carry[i+:2]})) begin
        // R2
        if (leaf[i].g) begin
          gen_carry_chk: assert (carry[i+1] == 1'b1)
            else $error("generate at bit %0d did not set carry", i);
        end
        // R3
        if (!leaf[i].g && !leaf[i].p) begin
          kill_carry_chk: assert (carry[i+1] == 1'b0)
            else $error("kill at bit %0d did not clear carry", i);
        end
        // R4
        if (leaf[i].p) begin
          prop_carry_chk: assert (carry[i+1] == carry[i])
            else $error("propagate at bit %0d altered carry", i);
        end
      end
    end
  end

  assign cout = carry[N];

  // R4
  always_comb begin
    if (!$isunknown({leaf, cin, cout}) && (&{leaf[N-1].p, pre[N-1].p})) begin
      all_prop_chk: assert (cout == cin)
        else $error("full propagate chain did not pass carry_in");
    end
  end

endmodule

// File: rtl/bk_prefix_adder.sv
module bk_prefix_adder
  import bkpa_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] opnd_a,
  input  logic [N-1:0] opnd_b,
  input  logic         carry_in,
  output logic [N-1:0] sum_out,
  output logic         carry_out
);

  // R6: the tree shape needs a power-of-two width of at least 4.
  if ((N < 4) || ((N & (N - 1)) != 0)) begin : g_bad_width
    $error("bk_prefix_adder: N=%0d must be a power of two >= 4", N);
  end

  // Reference arithmetic kept in one function for the checks.
  function automatic logic [N:0] ref_add(input logic [N-1:0] x,
                                         input logic [N-1:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
  endfunction

  gp_t [N-1:0] leaf;
  gp_t [N-1:0] pre;

  bk_bitcell #(.N(N)) u_bits (
    .a    (opnd_a),
    .b    (opnd_b),
    .leaf (leaf)
  );

  bk_prefix_tree #(.N(N)) u_tree (
    .leaf (leaf),
    .pre  (pre)
  );

  bk_sum_stage #(.N(N)) u_sum (
    .leaf (leaf),
    .pre  (pre),
    .cin  (carry_in),
    .s    (sum_out),
    .cout (carry_out)
  );

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, carry_in, sum_out, carry_out})) begin
      // R1
      arith_match_chk: assert ({carry_out, sum_out} == ref_add(opnd_a, opnd_b, carry_in))
        else $error("sum mismatch a=%h b=%h c=%b", opnd_a, opnd_b, carry_in);
      // R5
      if ((opnd_a == '0) && (opnd_b == '0)) begin
        cin_weight_chk: assert ((sum_out == {{(N-1){1'b0}}, carry_in}) && !carry_out)
          else $error("carry_in not added at weight 1");
      end
    end
  end

endmodule

// File: tb/test_bk_prefix_adder.sv
`timescale 1ns/100ps
module test_bk_prefix_adder;

  localparam int W  = 16;
  localparam int W8 = 8;
  localparam int WATCHDOG = 150000;
  localparam int NVEC = 12;

  // Each entry: {a, b, cin, cout, sum}
  localparam logic [49:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {16'hFFFF, 16'h0001, 1'b0, 1'b1, 16'h0000},
    {16'hFFFF, 16'h0000, 1'b1, 1'b1, 16'h0000},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 16'hFFFE},
    {16'h8000, 16'h8000, 1'b0, 1'b1, 16'h0000},
    {16'h1234, 16'h4321, 1'b0, 1'b0, 16'h5555},
    {16'h7FFF, 16'h0001, 1'b0, 1'b0, 16'h8000},
    {16'hAAAA, 16'h5555, 1'b0, 1'b0, 16'hFFFF},
    {16'hAAAA, 16'h5555, 1'b1, 1'b1, 16'h0000},
    {16'h00FF, 16'h0001, 1'b0, 1'b0, 16'h0100},
    {16'h0F0F, 16'hF0F1, 1'b0, 1'b1, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [W-1:0]  a16 = '0, b16 = '0, s16;
  logic          c16 = 1'b0, co16;
  logic [W8-1:0] a8 = '0, b8 = '0, s8;
  logic          c8 = 1'b0, co8;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  bk_prefix_adder #(.N(W)) i_bk_prefix_adder (
    .opnd_a (a16), .opnd_b (b16), .carry_in (c16),
    .sum_out (s16), .carry_out (co16)
  );

  bk_prefix_adder #(.N(W8)) i_bk_prefix_adder_w8 (
    .opnd_a (a8), .opnd_b (b8), .carry_in (c8),
    .sum_out (s8), .carry_out (co8)
  );

  task automatic expect17(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h c=%b actual=%h expected=%h", req, a16, b16, c16, act, exp);
    end
  endtask

  task automatic drive16(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    a16 = a; b16 = b; c16 = c;
    #1;
  endtask

  always @(posedge clk) begin
    if (!rst) cyc++;
    if (cyc == WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d cycles", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #10 rst = 1'b0;

    // R7: all-zero inputs give an all-zero result, no clock needed.
    drive16('0, '0, 1'b0);
    expect17("R7", {co16, s16}, 17'h0);

    // R1: vector table.
    for (int v = 0; v < NVEC; v++) begin
      drive16(VEC[v][49:34], VEC[v][33:18], VEC[v][17]);
      expect17("R1", {co16, s16}, VEC[v][16:0]);
    end

    // R5: carry_in at weight 1.
    drive16('0, '0, 1'b1);
    expect17("R5", {co16, s16}, 17'h00001);

    // R4: full-length propagate chains.
    for (int c = 0; c < 2; c++) begin
      drive16(16'h3C5A, ~16'h3C5A, c[0]);
      expect17("R4", {co16, s16}, c[0] ? 17'h10000 : 17'h0FFFF);
    end

    // R2 / R3: forced generate or kill at every position.
    for (int k = 0; k < W - 1; k++) begin
      for (int rep = 0; rep < 8; rep++) begin
        logic [W-1:0] ra, rb;
        logic rc;
        logic [16:0] want;
        ra = W'($urandom); rb = W'($urandom); rc = 1'($urandom);
        ra[k] = 1'b1; rb[k] = 1'b1;
        drive16(ra, rb, rc);
        expect17("R2", {16'h0, s16[k+1] ^ ra[k+1] ^ rb[k+1]}, 17'h1);
        ra[k] = 1'b0; rb[k] = 1'b0;
        drive16(ra, rb, rc);
        expect17("R3", {16'h0, s16[k+1] ^ ra[k+1] ^ rb[k+1]}, 17'h0);
        want = {1'b0, ra} + {1'b0, rb} + {16'h0, rc};
        expect17("R1", {co16, s16}, want);
      end
    end

    // R1: random 16-bit operands.
    for (int r = 0; r < 3000; r++) begin
      logic [W-1:0] ra, rb;
      logic rc;
      ra = W'($urandom); rb = W'($urandom); rc = 1'($urandom);
      drive16(ra, rb, rc);
      expect17("R1", {co16, s16}, {1'b0, ra} + {1'b0, rb} + {16'h0, rc});
    end

    // R6: exhaustive at N=8.
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          logic [8:0] want8;
          a8 = x[7:0]; b8 = y[7:0]; c8 = c[0];
          #1;
          want8 = 9'(x + y + c);
          n_chk++;
          if ({co8, s8} !== want8) begin
            n_fail++;
            $display("FAIL R6 a=%h b=%h c=%b actual=%h expected=%h",
                     a8, b8, c8, {co8, s8}, want8);
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule